// File: doc/BRIEF.md
# Streaming Internet Checksum Engine

This block produces the 16-bit one's complement checksum of a byte buffer delivered as a stream of 32-bit words. A one-cycle start pulse, sampled while the engine is idle, supplies the buffer's length in bytes and selects generate or verify mode. The engine then accepts words through a valid/ready handshake and adds each one, as a plain unsigned number, into a wide accumulator. After the last word it reduces the accumulator to 16 bits in a few folding cycles. It then presents the inverted result together with a one-cycle done strobe.

Words are read big-endian: the first byte of the buffer is the most significant byte of the first word. If the length is not a multiple of four, the bytes of the final word that lie past the end of the buffer are cleared before that word is added. As a result, an odd length behaves as if one zero byte had been appended. In verify mode the buffer is expected to contain its stored checksum field. The match flag is raised when the recomputed checksum is zero.

Top module: `inet_csum_stream`

## Requirements
- R1: csum_o equals the bitwise inverse of the end-around-carry sum of all 16-bit words of the buffer. Each word is formed big-endian, with byte 2i in bits 15:8 and byte 2i+1 in bits 7:0. A zero-length buffer gives 16'hFFFF.
- R2: When the length is odd, the last byte is paired with a zero low byte. In the last word, bytes at positions at or beyond len_i are ignored, whatever their value. Byte 0 of each word is in_data_i[31:24].
- R3: A buffer of 65536 bytes, all 8'hFF, loses no carry in the accumulator.
- R4: When the one's complement sum is 16'hFFFF, csum_o is 16'h0000, with no substitution.
- R5: done_o is high for exactly one cycle per buffer. csum_o and match_o then hold their values until the next buffer completes.
- R6: match_o is 1 after a buffer only if verify_i was 1 at its start pulse and the resulting csum_o is 16'h0000. Otherwise match_o is 0.
- R7: in_ready_o is high only while words of the current buffer remain. Words offered while the engine is idle are not consumed. A start pulse while a buffer is in progress is ignored.
- R8: After reset, done_o, match_o and in_ready_o are 0 and csum_o is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a buffer when the engine is idle |
| len_i | input | LEN_W | Buffer length in bytes, sampled with start_i |
| verify_i | input | 1 | Verify mode, sampled with start_i |
| in_valid_i | input | 1 | A data word is offered |
| in_data_i | input | 32 | Data word, first byte in the top bits |
| in_ready_o | output | 1 | Engine accepts a word this cycle |
| done_o | output | 1 | One-cycle result strobe |
| csum_o | output | 16 | Inverted folded sum |
| match_o | output | 1 | Verify result is zero |

## Verification
The bench uses the default parameters: LEN_W of 17 and a 64-bit accumulator. With these values a full 65536-byte buffer can be sent, so the largest legal sum and a multi-step fold are exercised. Short buffers of every length modulo four are sent with garbage in the unused tail bytes and with random gaps in valid. This reaches the masking logic, the odd-length pairing, the handshake stall path, the zero-sum output case and the verify flag in both outcomes.

// File: rtl/inet_csum_stream.sv
module inet_csum_stream #(
  parameter int LEN_W = 17,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             verify_i,
  input  logic             in_valid_i,
  input  logic [31:0]      in_data_i,
  output logic             in_ready_o,
  output logic             done_o,
  output logic [15:0]      csum_o,
  output logic             match_o
);
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int HI_W   = ACC_W - WORD_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FOLD, S_FINAL} state_t;

  state_t              state;
  logic [ACC_W-1:0]    acc;
  logic [LEN_W-1:0]    cnt;
  logic [1:0]          tail;
  logic                verify_q;
  logic [LEN_W:0]      len_up;
  logic [LEN_W-1:0]    words;
  logic [WORD_W-1:0]   mask;
  logic [HI_W-1:0]     acc_hi;
  logic [16:0]         half_sum;
  logic [15:0]         fold16;

  assign len_up     = {1'b0, len_i} + (LEN_W+1)'(BYTES - 1);
  assign words      = len_up[LEN_W:2];
  assign in_ready_o = (state == S_RUN);
  assign acc_hi     = acc[ACC_W-1:WORD_W];
  assign half_sum   = {1'b0, acc[31:16]} + {1'b0, acc[15:0]};
  assign fold16     = half_sum[15:0] + {15'd0, half_sum[16]};

  always_comb begin
    mask = '1;
    if (cnt == LEN_W'(1) && tail != 2'd0) begin
      for (int b = 0; b < BYTES; b++) begin
        if (b >= int'(tail)) mask[WORD_W-1-8*b -: 8] = 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      acc      <= '0;
      cnt      <= '0;
      tail     <= '0;
      verify_q <= 1'b0;
      done_o   <= 1'b0;
      csum_o   <= '0;
      match_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          acc      <= '0;
          cnt      <= words;
          tail     <= len_i[1:0];
          verify_q <= verify_i;
          state    <= (words == '0) ? S_FOLD : S_RUN;
        end
        S_RUN: if (in_valid_i) begin
          acc <= acc + ACC_W'(in_data_i & mask);
          cnt <= cnt - LEN_W'(1);
          if (cnt == LEN_W'(1)) state <= S_FOLD;
        end
        S_FOLD: begin
          if (acc_hi != '0) acc <= ACC_W'(acc[WORD_W-1:0]) + ACC_W'(acc_hi);
          else              state <= S_FINAL;
        end
        default: begin
          csum_o  <= ~fold16;
          match_o <= verify_q && (fold16 == 16'hFFFF);
          done_o  <= 1'b1;
          state   <= S_IDLE;
        end
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> !acc[ACC_W-1]);
  assert_fold_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FOLD && acc_hi != '0) |=> (acc < $past(acc)));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(csum_o) && $stable(match_o)));
  assert_match_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (csum_o == 16'h0000));
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !in_ready_o);
endmodule

// File: tb/inet_csum_stream_tb.sv
module inet_csum_stream_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [16:0] len_i = '0;
  logic        verify_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o, done_o, match_o;
  logic [15:0] csum_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  mem [0:65539];
  logic [15:0] got_csum;
  logic        got_match;

  always #5 clk = ~clk;

  inet_csum_stream dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .verify_i(verify_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .done_o(done_o), .csum_o(csum_o), .match_o(match_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_csum(input int n);
    int unsigned s = 0;
    for (int i = 0; i < n; i += 2)
      s += {16'h0, mem[i], (i + 1 < n) ? mem[i+1] : 8'h00};
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic run_buf(input int n, input bit ver, input int gap, input bit poke);
    int nw = (n + 3) / 4;
    int k = 0;
    int t = 0;
    bit hs;
    @(negedge clk);
    start_i = 1'b1; len_i = 17'(n); verify_i = ver;
    @(negedge clk);
    start_i = 1'b0;
    while (k < nw) begin
      in_valid_i = (gap == 0) || (($urandom % gap) != 0);
      in_data_i  = {mem[4*k], mem[4*k+1], mem[4*k+2], mem[4*k+3]};
      if (poke && k == 1) begin start_i = 1'b1; len_i = 17'd4; end
      else start_i = 1'b0;
      hs = in_valid_i && in_ready_o;
      @(negedge clk);
      if (hs) k++;
    end
    in_valid_i = 1'b0; start_i = 1'b0;
    while (!done_o && t < 200) begin @(negedge clk); t++; end
    chk("R5 done seen", {31'd0, done_o}, 32'd1);
    got_csum = csum_o; got_match = match_o;
    @(negedge clk);
    chk("R5 done one cycle", {31'd0, done_o}, 32'd0);
    chk("R5 csum held", {16'd0, csum_o}, {16'd0, got_csum});
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) mem[i] = 8'((i * 37 + seed * 11 + (i >> 3)) ^ seed);
    for (int i = n; i < n + 4; i++) mem[i] = 8'hA5;
  endtask

  task automatic t_reset;
    chk("R8 done", {31'd0, done_o}, 32'd0);
    chk("R8 match", {31'd0, match_o}, 32'd0);
    chk("R8 ready", {31'd0, in_ready_o}, 32'd0);
    chk("R8 csum", {16'd0, csum_o}, 32'd0);
  endtask

  task automatic t_endian;
    mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'hFF; mem[3] = 8'hFF;
    run_buf(2, 1'b0, 0, 1'b0);
    chk("R1 big-endian word", {16'd0, got_csum}, 32'h0000EDCB);
    run_buf(0, 1'b0, 0, 1'b0);
    chk("R1 empty buffer", {16'd0, got_csum}, 32'h0000FFFF);
  endtask

  task automatic t_lengths;
    for (int n = 1; n <= 13; n++) begin
      fill(n, n);
      run_buf(n, 1'b0, 3, 1'b0);
      chk($sformatf("R2 R1 len %0d", n), {16'd0, got_csum}, {16'd0, ref_csum(n)});
    end
    fill(1501, 7);
    run_buf(1501, 1'b0, 4, 1'b0);
    chk("R1 len 1501", {16'd0, got_csum}, {16'd0, ref_csum(1501)});
  endtask

  task automatic t_full;
    for (int i = 0; i < 65536; i++) mem[i] = 8'hFF;
    run_buf(65536, 1'b0, 0, 1'b0);
    chk("R3 R4 64KB all ones", {16'd0, got_csum}, 32'h00000000);
    chk("R6 no match outside verify", {31'd0, got_match}, 32'd0);
    fill(65536, 3);
    run_buf(65536, 1'b0, 0, 1'b0);
    chk("R3 64KB pattern", {16'd0, got_csum}, {16'd0, ref_csum(65536)});
  endtask

  task automatic t_verify;
    logic [15:0] c;
    fill(21, 9);
    mem[10] = 8'h00; mem[11] = 8'h00;
    c = ref_csum(21);
    mem[10] = c[15:8]; mem[11] = c[7:0];
    run_buf(21, 1'b1, 2, 1'b0);
    chk("R6 verify good csum", {16'd0, got_csum}, 32'd0);
    chk("R6 verify match", {31'd0, got_match}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 match held", {31'd0, match_o}, 32'd1);
    mem[4] = mem[4] ^ 8'h40;
    run_buf(21, 1'b1, 2, 1'b0);
    chk("R6 verify corrupted", {31'd0, got_match}, 32'd0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    in_valid_i = 1'b1; in_data_i = 32'hDEADBEEF;
    repeat (3) begin
      @(negedge clk);
      chk("R7 idle not ready", {31'd0, in_ready_o}, 32'd0);
    end
    in_valid_i = 1'b0;
    fill(40, 5);
    run_buf(40, 1'b0, 2, 1'b1);
    chk("R7 start while busy ignored", {16'd0, got_csum}, {16'd0, ref_csum(40)});
    chk("R7 idle after done", {31'd0, in_ready_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_endian();
    t_lengths();
    t_verify();
    t_busy();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule